// File: doc/BRIEF.md
# ATA PIO Bus Cycle Generator

This block turns single register or data requests from a host into timed parallel ATA programmed I/O cycles. It drives an IDE disk or a CompactFlash card that runs in its true IDE mode. The host raises a request together with a direction flag, a block-select flag, a register address and 16-bit write data. It keeps the request high until a one-cycle done pulse comes back, and read data is valid with that pulse. On the device side the block drives two active-low chip selects, the read and write strobes, a 3-bit register address and a 16-bit data bus. The data bus is split into an output, an output enable and an input, so the pad ring can build the tristate. The block also samples a ready input from the device.

The cycle timing comes from three configuration registers that hold clock counts: cycle length, strobe setup and strobe pulse. They load together through a write strobe and come out of reset with values that meet PIO mode 0 at a 50 MHz clock. Reads and writes use the same timing. The block always adds one setup clock to absorb line ringing. It lengthens the cycle when needed so that the strobe has at least two clocks of recovery. The chip-select window sits inside the cycle at a fixed offset, and the strobe is held for as long as the device reports not-ready.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset both chip selects and both strobes are high, the data output enable is low and done is low.
- R2: Counting the cycle's first clock as 0, the selected chip select is low from clock 1 for T-2 clocks (plus any wait clocks), where T is the effective cycle length from R5.
- R3: The strobe goes low setup+1 clocks after the cycle starts, so exactly `setup` chip-select clocks come before it.
- R4: Without wait states the strobe stays low for exactly `pulse` clocks.
- R5: The effective cycle length is T = max(cycle, setup+pulse+3), so the strobe recovery is never shorter than two clocks. Done is high in the cycle's last clock, which is T clocks after the request is accepted, plus any wait clocks.
- R6: On a read, the data bus value present in the last strobe-low clock is captured as the strobe rises and appears on `h_rdata` with done.
- R7: On a write, the output enable is high for the whole chip-select window and the latched write data is on `ide_d_out`. On a read the output enable stays low.
- R8: With `h_ctl`=0 the access uses the command block (`ide_cs0_n` low, `ide_cs1_n` high) and `ide_a` equals host address bits 3:1. With `h_ctl`=1 it uses the control block (`ide_cs1_n` low, `ide_cs0_n` high) and `ide_a` is forced to 6. The two selects are never low together.
- R9: While a strobe is low and `ide_iordy` is sampled low, the cycle counter stops, so each not-ready clock lengthens the strobe and the chip-select window by one clock.
- R10: Until the first configuration write, the timing is cycle 30, setup 4, pulse 15.
- R11: Only one transfer runs at a time. Direction, address, block select and write data are latched when the request is accepted, so changing the host inputs during the cycle has no effect on it. Done is a single-clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Loads the three timing registers |
| cfg_cycle | input | 8 | Cycle length in clocks |
| cfg_setup | input | 8 | Strobe setup in clocks (one clock is added) |
| cfg_pulse | input | 8 | Strobe low time in clocks |
| h_req | input | 1 | Transfer request, held until done |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_ctl | input | 1 | 1 = control block, 0 = command block |
| h_addr | input | 3 | Host address bits 3:1 |
| h_wdata | input | 16 | Write data |
| h_rdata | output | 16 | Read data, valid with done |
| h_done | output | 1 | One-clock completion pulse |
| ide_cs0_n | output | 1 | Command block select, active low |
| ide_cs1_n | output | 1 | Control block select, active low |
| ide_dior_n | output | 1 | Read strobe, active low |
| ide_diow_n | output | 1 | Write strobe, active low |
| ide_a | output | 3 | Device register address |
| ide_d_out | output | 16 | Data bus output value |
| ide_d_oe | output | 1 | Data bus output enable |
| ide_d_in | input | 16 | Data bus input value |
| ide_iordy | input | 1 | Device ready, low stretches the strobe |

## Verification
The assertions assume that the host holds `h_req` until done and drops it in the clock where done is high. They also assume that `ide_iordy` goes low only for a bounded number of clocks. Under those conditions strobes nest inside the selects, a stalled strobe stays low, and done cannot repeat back to back. The bench keeps within these rules: its driver releases the request at the sampled done, and its device model pulls ready low only during a strobe, for a fixed count chosen per transfer.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } pio_state_e;

  // request fields latched at the start of a cycle
  typedef struct packed {
    logic       wr;
    logic       ctl;
    logic [2:0] reg_a;
  } pio_req_t;

  localparam logic [2:0] CTL_REG_ADDR = 3'd6;

endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs #(
  parameter int CNT_W     = 8,
  parameter int RST_CYCLE = 30,
  parameter int RST_SETUP = 4,
  parameter int RST_PULSE = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CNT_W-1:0] cycle_in,
  input  logic [CNT_W-1:0] setup_in,
  input  logic [CNT_W-1:0] pulse_in,
  output logic [CNT_W-1:0] cycle_q,
  output logic [CNT_W-1:0] setup_q,
  output logic [CNT_W-1:0] pulse_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycle_q <= CNT_W'(RST_CYCLE);
      setup_q <= CNT_W'(RST_SETUP);
      pulse_q <= CNT_W'(RST_PULSE);
    end else if (we) begin
      cycle_q <= cycle_in;
      setup_q <= setup_in;
      pulse_q <= pulse_in;
    end
  end

endmodule

// File: rtl/pio_timing_calc.sv
module pio_timing_calc #(
  parameter int CNT_W = 8,
  parameter int TW    = CNT_W + 2
) (
  input  logic [CNT_W-1:0] cycle,
  input  logic [CNT_W-1:0] setup,
  input  logic [CNT_W-1:0] pulse,
  output logic [TW-1:0]    t_on,
  output logic [TW-1:0]    t_off,
  output logic [TW-1:0]    t_tot
);

  logic [TW-1:0] floor_len;

  always_comb begin
    t_on      = TW'(setup) + TW'(1);        // one extra settle clock
    t_off     = t_on + TW'(pulse);
    floor_len = t_off + TW'(2);             // two clocks of recovery minimum
    t_tot     = (TW'(cycle) < floor_len) ? floor_len : TW'(cycle);
  end

endmodule

// File: rtl/pio_seq.sv
module pio_seq
  import pio_pkg::*;
#(
  parameter int TW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  pio_req_t      req_in,
  input  logic [DW-1:0] wdata_in,
  input  logic [TW-1:0] t_on,
  input  logic [TW-1:0] t_off,
  input  logic [TW-1:0] t_tot,
  input  logic          iordy,
  input  logic [DW-1:0] dd_in,
  output logic          cs_win,
  output logic          strb,
  output logic          done,
  output pio_req_t      req_q,
  output logic [DW-1:0] wd_q,
  output logic [DW-1:0] rd_q
);

  pio_state_e    state_q, state_d;
  logic [TW-1:0] t_q, t_d;
  logic [TW-1:0] on_q, off_q, tot_q;
  logic          run, stall, last, ld_en, cap_en;

  always_comb begin
    run    = (state_q == ST_RUN);
    cs_win = run && (t_q != '0) && (t_q <= tot_q - TW'(2));
    strb   = run && (t_q >= on_q) && (t_q < off_q);
    stall  = strb && !iordy;
    last   = run && (t_q == tot_q - TW'(1));
    done   = last;
    ld_en  = !run && start;
    cap_en = strb && !stall && !req_q.wr && (t_q == off_q - TW'(1));

    state_d = state_q;
    t_d     = t_q;
    if (ld_en) begin
      state_d = ST_RUN;
      t_d     = '0;
    end else if (last) begin
      state_d = ST_IDLE;
    end else if (run && !stall) begin
      t_d = t_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      t_q     <= '0;
    end else begin
      state_q <= state_d;
      t_q     <= t_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= '0;
      off_q <= '0;
      tot_q <= '0;
      req_q <= '0;
      wd_q  <= '0;
    end else if (ld_en) begin
      on_q  <= t_on;
      off_q <= t_off;
      tot_q <= t_tot;
      req_q <= req_in;
      wd_q  <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (cap_en) begin
      rd_q <= dd_in;
    end
  end

endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
  import pio_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DW        = 16,
  parameter int RST_CYCLE = 30,
  parameter int RST_SETUP = 4,
  parameter int RST_PULSE = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_cycle,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_pulse,
  input  logic             h_req,
  input  logic             h_wr,
  input  logic             h_ctl,
  input  logic [3:1]       h_addr,
  input  logic [DW-1:0]    h_wdata,
  output logic [DW-1:0]    h_rdata,
  output logic             h_done,
  output logic             ide_cs0_n,
  output logic             ide_cs1_n,
  output logic             ide_dior_n,
  output logic             ide_diow_n,
  output logic [2:0]       ide_a,
  output logic [DW-1:0]    ide_d_out,
  output logic             ide_d_oe,
  input  logic [DW-1:0]    ide_d_in,
  input  logic             ide_iordy
);

  localparam int TW = CNT_W + 2;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [CNT_W-1:0] cyc_q, set_q, pul_q;
  logic [TW-1:0]    t_on, t_off, t_tot;
  pio_req_t         req_in, req_q;
  logic             cs_win, strb;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pio_cfg_regs #(
    .CNT_W(CNT_W), .RST_CYCLE(RST_CYCLE), .RST_SETUP(RST_SETUP), .RST_PULSE(RST_PULSE)
  ) i_cfg (
    .clk(clk), .rst_n(rst_int_n), .we(cfg_we),
    .cycle_in(cfg_cycle), .setup_in(cfg_setup), .pulse_in(cfg_pulse),
    .cycle_q(cyc_q), .setup_q(set_q), .pulse_q(pul_q)
  );

  pio_timing_calc #(.CNT_W(CNT_W), .TW(TW)) i_calc (
    .cycle(cyc_q), .setup(set_q), .pulse(pul_q),
    .t_on(t_on), .t_off(t_off), .t_tot(t_tot)
  );

  always_comb begin
    req_in.wr    = h_wr;
    req_in.ctl   = h_ctl;
    req_in.reg_a = h_ctl ? CTL_REG_ADDR : h_addr;
  end

  pio_seq #(.TW(TW), .DW(DW)) i_seq (
    .clk(clk), .rst_n(rst_int_n), .start(h_req),
    .req_in(req_in), .wdata_in(h_wdata),
    .t_on(t_on), .t_off(t_off), .t_tot(t_tot),
    .iordy(ide_iordy), .dd_in(ide_d_in),
    .cs_win(cs_win), .strb(strb), .done(h_done),
    .req_q(req_q), .wd_q(ide_d_out), .rd_q(h_rdata)
  );

  always_comb begin
    ide_cs0_n  = !(cs_win && !req_q.ctl);
    ide_cs1_n  = !(cs_win && req_q.ctl);
    ide_dior_n = !(strb && !req_q.wr);
    ide_diow_n = !(strb && req_q.wr);
    ide_d_oe   = cs_win && req_q.wr;
    ide_a      = req_q.reg_a;
  end

endmodule

// File: rtl/pio_strobe_chk.sv
module pio_strobe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       h_done,
  input logic       ide_cs0_n,
  input logic       ide_cs1_n,
  input logic       ide_dior_n,
  input logic       ide_diow_n,
  input logic       ide_d_oe,
  input logic       ide_iordy,
  input logic [2:0] ide_a
);

  logic sel_on;
  assign sel_on = !ide_cs0_n || !ide_cs1_n;

  a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_dior_n && !ide_diow_n));

  a_r2_strobe_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_dior_n || !ide_diow_n) |-> sel_on);

  a_r5_recovery_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ide_dior_n) || $rose(ide_diow_n)) |-> !h_done);

  a_r7_oe_only_write_window: assert property (@(posedge clk) disable iff (!rst_n)
    ide_d_oe |-> (sel_on && ide_dior_n));

  a_r8_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_cs0_n && !ide_cs1_n));

  a_r9_read_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_dior_n && !ide_iordy) |=> !ide_dior_n);

  a_r9_write_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_diow_n && !ide_iordy) |=> !ide_diow_n);

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    h_done |=> !h_done);

  a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_on && $past(sel_on)) |-> $stable(ide_a));

endmodule

bind pio_strobe_gen pio_strobe_chk i_chk (
  .clk(clk), .rst_n(rst_n), .h_done(h_done),
  .ide_cs0_n(ide_cs0_n), .ide_cs1_n(ide_cs1_n),
  .ide_dior_n(ide_dior_n), .ide_diow_n(ide_diow_n),
  .ide_d_oe(ide_d_oe), .ide_iordy(ide_iordy), .ide_a(ide_a)
);

// File: tb/test_pio_strobe_gen.sv
module test_pio_strobe_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_cycle, cfg_setup, cfg_pulse;
  logic        h_req, h_wr, h_ctl;
  logic [3:1]  h_addr;
  logic [15:0] h_wdata, h_rdata;
  logic        h_done;
  logic        ide_cs0_n, ide_cs1_n, ide_dior_n, ide_diow_n, ide_d_oe;
  logic [2:0]  ide_a;
  logic [15:0] ide_d_out, ide_d_in;
  logic        ide_iordy;

  always #10 clk = ~clk;   // 50 MHz

  pio_strobe_gen i_pio_strobe_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_cycle(cfg_cycle), .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse),
    .h_req(h_req), .h_wr(h_wr), .h_ctl(h_ctl), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_done(h_done),
    .ide_cs0_n(ide_cs0_n), .ide_cs1_n(ide_cs1_n),
    .ide_dior_n(ide_dior_n), .ide_diow_n(ide_diow_n),
    .ide_a(ide_a), .ide_d_out(ide_d_out), .ide_d_oe(ide_d_oe),
    .ide_d_in(ide_d_in), .ide_iordy(ide_iordy)
  );

  typedef struct {
    bit          wr;
    bit          ctl;
    bit [2:0]    a;
    int          pre;
    int          strb;
    int          cs;
    bit [15:0]   data;
  } exp_t;

  exp_t        sb_q[$];
  int          n_tests = 0, n_fail = 0;
  int          c_cycle = 30, c_setup = 4, c_pulse = 15;   // R10 reset values
  int          stall_left = 0;
  logic [15:0] rd_val = 16'h0;
  bit          finished = 0;

  // device model: read data only while the read strobe is low
  assign ide_d_in = !ide_dior_n ? rd_val : 16'hDEAD;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int cy, input int se, input int pu);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cycle = 8'(cy); cfg_setup = 8'(se); cfg_pulse = 8'(pu);
    @(negedge clk);
    cfg_we = 1'b0;
    c_cycle = cy; c_setup = se; c_pulse = pu;
  endtask

  // driver: compute expectation, push it, run one transfer
  task automatic xfer(input bit wr, input bit ctl, input logic [3:1] addr,
                      input logic [15:0] data, input int stall, input bit perturb);
    exp_t e;
    int   tot, k;
    tot    = (c_cycle > c_setup + c_pulse + 3) ? c_cycle : c_setup + c_pulse + 3;
    e.wr   = wr;
    e.ctl  = ctl;
    e.a    = ctl ? 3'd6 : addr;
    e.pre  = c_setup;
    e.strb = c_pulse + stall;
    e.cs   = tot - 2 + stall;
    e.data = data;
    sb_q.push_back(e);
    @(negedge clk);
    stall_left = stall;
    rd_val  = data;
    h_req   = 1'b1; h_wr = wr; h_ctl = ctl; h_addr = addr; h_wdata = data;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (perturb && k == 3) begin
        h_addr = ~addr; h_wdata = ~data; h_ctl = ~ctl; h_wr = ~wr;  // R11
      end
    end while (!h_done && k < 2000);
    h_req = 1'b0;
    chk(k == tot + stall, "R5", "request-to-done clocks", k, tot + stall);
  endtask

  // monitor: measure the bus cycle and compare at done
  int cs_cnt = 0, pre_cnt = 0, st_cnt = 0, oe_cnt = 0;
  bit saw_rd = 0, saw_wr = 0, cs0_seen = 0, cs1_seen = 0, wd_ok = 1;
  logic [2:0] a_seen = '0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (!ide_dior_n || !ide_diow_n) begin
        if (stall_left > 0) begin ide_iordy = 1'b0; stall_left--; end
        else ide_iordy = 1'b1;
      end else ide_iordy = 1'b1;

      if (!ide_cs0_n || !ide_cs1_n) begin
        cs_cnt++;
        a_seen = ide_a;
        if (!ide_cs0_n) cs0_seen = 1;
        if (!ide_cs1_n) cs1_seen = 1;
        if (ide_d_oe) oe_cnt++;
        if (!ide_dior_n || !ide_diow_n) begin
          st_cnt++;
          if (!ide_dior_n) saw_rd = 1;
          if (!ide_diow_n) saw_wr = 1;
          if (ide_d_out != (sb_q.size() > 0 ? sb_q[0].data : 16'h0)) wd_ok = 0;
        end else if (st_cnt == 0) pre_cnt++;
      end

      if (h_done) begin
        if (sb_q.size() == 0) begin
          chk(0, "R11", "done with no transfer pending", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(cs_cnt == e.cs, "R2", "select window clocks", cs_cnt, e.cs);
          chk(pre_cnt == e.pre, "R3", "select clocks before strobe", pre_cnt, e.pre);
          chk(st_cnt == e.strb, "R4/R9", "strobe clocks", st_cnt, e.strb);
          chk(a_seen == e.a, "R8", "register address", a_seen, e.a);
          chk(cs0_seen == !e.ctl && cs1_seen == e.ctl, "R8", "block select",
              {cs1_seen, cs0_seen}, {e.ctl, !e.ctl});
          chk(saw_wr == e.wr && saw_rd == !e.wr, "R11", "strobe direction",
              {saw_wr, saw_rd}, {e.wr, !e.wr});
          if (e.wr) begin
            chk(oe_cnt == e.cs, "R7", "output enable clocks", oe_cnt, e.cs);
            chk(wd_ok, "R7", "write data on bus", ide_d_out, e.data);
          end else begin
            chk(oe_cnt == 0, "R7", "output enable on read", oe_cnt, 0);
            chk(h_rdata == e.data, "R6", "read data", h_rdata, e.data);
          end
        end
        cs_cnt = 0; pre_cnt = 0; st_cnt = 0; oe_cnt = 0;
        saw_rd = 0; saw_wr = 0; cs0_seen = 0; cs1_seen = 0; wd_ok = 1;
      end
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_cycle = '0; cfg_setup = '0; cfg_pulse = '0;
    h_req = 1'b0; h_wr = 1'b0; h_ctl = 1'b0; h_addr = '0; h_wdata = '0;
    ide_iordy = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 idle outputs after reset
    chk(ide_cs0_n && ide_cs1_n && ide_dior_n && ide_diow_n && !ide_d_oe && !h_done,
        "R1", "idle outputs",
        {ide_cs0_n, ide_cs1_n, ide_dior_n, ide_diow_n, ide_d_oe, h_done}, 6'b111100);

    // R10 reset timing, command block read and write
    xfer(1'b0, 1'b0, 3'd1, 16'h00A5, 0, 0);
    xfer(1'b1, 1'b0, 3'd7, 16'h1234, 0, 0);
    // programmed timing, cycle longer than the minimum
    set_cfg(10, 2, 3);
    xfer(1'b0, 1'b0, 3'd3, 16'hBEEF, 0, 0);
    xfer(1'b1, 1'b0, 3'd5, 16'h5A5A, 0, 0);
    // R5 cycle extended for recovery, R8 control block forced to 6
    set_cfg(4, 1, 2);
    xfer(1'b1, 1'b1, 3'd2, 16'h0081, 0, 0);
    xfer(1'b0, 1'b1, 3'd0, 16'h0050, 0, 0);
    // zero setup: strobe opens with the select window
    set_cfg(0, 0, 1);
    xfer(1'b0, 1'b0, 3'd4, 16'hC3C3, 0, 0);
    // R9 not-ready stretching on read and write
    set_cfg(10, 2, 3);
    xfer(1'b0, 1'b0, 3'd6, 16'h7E7E, 3, 0);
    xfer(1'b1, 1'b0, 3'd2, 16'h0F0F, 2, 0);
    // R11 host inputs changed mid-cycle have no effect
    xfer(1'b1, 1'b0, 3'd1, 16'hA1B2, 0, 1);
    xfer(1'b0, 1'b1, 3'd3, 16'h9988, 1, 1);

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R11", "pending transfers at end", sb_q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule